// File: doc/BRIEF.md
# E1 Frame Alignment Supervisor

This block supervises timeslot 0 of a received E1 stream that an upstream hunter has already split into octets. Each octet arrives with a strobe that says whether its frame should carry the frame alignment signal or the service word. From this the block keeps a frame-alignment state. It declares loss of alignment after a programmable run of bad words. It then runs a three-frame regain check before it declares alignment again.

Once frame alignment is held, the block also rebuilds CRC multiframe alignment by counting 16-frame multiframes. It tracks the far-end alarm bit of the service word. Four sticky interrupt flags report the rise and the fall of the two alarm statuses. A simulation input forces both alarm statuses high for test.

Top module: `e1fas_supervisor`

## Requirements
- R1: An octet with `oct_fas_slot`=1 is an alignment word. It is correct when `oct_data[6:0]` (frame bits 2 to 8) equals 0011011. Bit 1 (`oct_data[7]`) is ignored. An octet with `oct_fas_slot`=0 is a service word: frame bit 2 is `oct_data[6]` and frame bit 3 is `oct_data[5]`.
- R2: While aligned, a run of consecutive incorrect alignment words sets `st_lfa`. The run length is 3 when `cfg_loss4`=0 and 4 when `cfg_loss4`=1. A correct alignment word restarts the run.
- R3: While aligned, a run of consecutive service words with bit 2 = 0 sets `st_lfa`, using the same run length as R2. This criterion is off when `cfg_sw_chk_en`=0.
- R4: While out of alignment, `st_lfa` clears only after three octets in a row: a correct alignment word, then a service word with bit 2 = 1, then a correct alignment word. The clear is visible on the clock edge that takes the third octet.
- R5: Any failed step of the regain check restarts it. The next alignment-slot octet is then the new first candidate. Service-slot octets that arrive while no candidate is held are ignored.
- R6: `irq_lfa` sets when `st_lfa` rises, and `irq_far` sets when `st_lfa` falls. Coming out of reset raises neither flag.
- R7: `st_rra` takes bit 3 of each service word received while aligned. It holds its value while out of alignment. `irq_ra` sets when `st_rra` rises and `irq_rar` sets when it falls.
- R8: While `cfg_sim`=1, `st_lfa` and `st_rra` read 1 from the next edge onward, and their interrupts follow the changes. When simulation ends, each status falls only if no real alarm condition exists.
- R9: With `cfg_crc_mf_en`=1, loss of frame alignment sets `st_lmfa` one cycle after the loss. After alignment returns, octets are counted in 16-frame multiframes, starting with the first octet after the clear. `st_lmfa` clears at the end of the second consecutive multiframe that holds no incorrect alignment word. A bad word resets the count of good multiframes. With `cfg_crc_mf_en`=0, `st_lmfa` reads 0.
- R10: The interrupt flags stay set until `irq_clr`. A new event in the same cycle as `irq_clr` leaves its flag set.
- R11: After reset, `st_lfa`=1, `st_rra`=0, all interrupt flags are 0, and the block is searching for a first candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| oct_vld | input | 1 | Timeslot-0 octet valid this cycle |
| oct_data | input | 8 | Timeslot-0 octet, bit 7 = frame bit 1 |
| oct_fas_slot | input | 1 | 1 = alignment-word frame, 0 = service-word frame |
| cfg_loss4 | input | 1 | Loss run length 4 (1) or 3 (0) |
| cfg_sw_chk_en | input | 1 | Count bad service words towards loss |
| cfg_crc_mf_en | input | 1 | Enable CRC multiframe supervision |
| cfg_sim | input | 1 | Force alarm statuses |
| irq_clr | input | 1 | Clear all interrupt flags |
| st_lfa | output | 1 | Loss of frame alignment status |
| st_rra | output | 1 | Remote alarm status |
| st_lmfa | output | 1 | Loss of multiframe alignment status |
| irq_lfa | output | 1 | Sticky: frame alignment lost |
| irq_far | output | 1 | Sticky: frame alignment recovered |
| irq_ra | output | 1 | Sticky: remote alarm raised |
| irq_rar | output | 1 | Sticky: remote alarm removed |

## Verification
Two things can land in the same cycle: the interrupt clear strobe, and an alignment or alarm event that sets a flag. The bench provokes this by raising `irq_clr` on the same cycle as the octet that completes a regain. It expects `irq_far` to read 1 afterward, while the other flags read 0. The simulation release and a real loss can also overlap. The bench turns simulation off during a real loss and expects `st_lfa` to stay high with no recovery flag.

// File: rtl/e1fas_pkg.sv
package e1fas_pkg;
    localparam int        OCT_W       = 8;
    localparam logic [6:0] ALIGN_PAT  = 7'b0011011;
    localparam int        SW_KEEP_POS = 6;   // frame bit 2
    localparam int        SW_RA_POS   = 5;   // frame bit 3
    localparam int        IRQ_N       = 4;
    localparam int        IRQ_LFA     = 0;
    localparam int        IRQ_FAR     = 1;
    localparam int        IRQ_RA      = 2;
    localparam int        IRQ_RAR     = 3;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_GOT_A  = 2'd1,
        ST_GOT_SW = 2'd2,
        ST_SYNC   = 2'd3
    } align_st_e;
endpackage

// File: rtl/e1fas_word_check.sv
module e1fas_word_check
    import e1fas_pkg::*;
(
    input  logic             oct_vld,
    input  logic [OCT_W-1:0] oct_data,
    input  logic             oct_fas_slot,
    output logic             vld_align,
    output logic             vld_sw,
    output logic             align_ok,
    output logic             sw_keep,
    output logic             sw_ra
);
    always_comb begin
        vld_align = oct_vld & oct_fas_slot;
        vld_sw    = oct_vld & ~oct_fas_slot;
        // frame bit 1 (oct_data[7]) carries no alignment meaning
        align_ok  = (oct_data[6:0] == ALIGN_PAT);
        sw_keep   = oct_data[SW_KEEP_POS];
        sw_ra     = oct_data[SW_RA_POS];
    end
endmodule

// File: rtl/e1fas_align_fsm.sv
module e1fas_align_fsm
    import e1fas_pkg::*;
#(
    parameter int LOSS_LO = 3,
    parameter int LOSS_HI = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vld_align,
    input  logic vld_sw,
    input  logic align_ok,
    input  logic sw_keep,
    input  logic sw_ra,
    input  logic cfg_loss4,
    input  logic cfg_sw_chk_en,
    output logic lfa_d,
    output logic lfa_q,
    output logic rra_d
);
    localparam int CNT_W = $clog2(LOSS_HI + 1);

    typedef struct packed {
        align_st_e        st;
        logic [CNT_W-1:0] bad_a;
        logic [CNT_W-1:0] bad_sw;
        logic             rra;
    } fsm_t;

    fsm_t             cur_q, nxt_d;
    logic [CNT_W-1:0] thr;

    always_comb begin
        nxt_d = cur_q;
        thr   = cfg_loss4 ? CNT_W'(LOSS_HI) : CNT_W'(LOSS_LO);
        unique case (cur_q.st)
            ST_HUNT: begin
                if (vld_align && align_ok) nxt_d.st = ST_GOT_A;
            end
            ST_GOT_A: begin
                if (vld_sw)         nxt_d.st = sw_keep ? ST_GOT_SW : ST_HUNT;
                else if (vld_align) nxt_d.st = ST_HUNT;
            end
            ST_GOT_SW: begin
                if (vld_align) begin
                    if (align_ok) begin
                        nxt_d.st     = ST_SYNC;
                        nxt_d.bad_a  = '0;
                        nxt_d.bad_sw = '0;
                    end else begin
                        nxt_d.st = ST_HUNT;
                    end
                end else if (vld_sw) begin
                    nxt_d.st = ST_HUNT;
                end
            end
            default: begin
                if (vld_align) begin
                    if (align_ok) begin
                        nxt_d.bad_a = '0;
                    end else begin
                        nxt_d.bad_a = cur_q.bad_a + CNT_W'(1);
                        if (nxt_d.bad_a >= thr) nxt_d.st = ST_HUNT;
                    end
                end
                if (vld_sw) begin
                    nxt_d.rra = sw_ra;
                    if (sw_keep) begin
                        nxt_d.bad_sw = '0;
                    end else begin
                        if (cur_q.bad_sw < thr) nxt_d.bad_sw = cur_q.bad_sw + CNT_W'(1);
                        if (cfg_sw_chk_en && nxt_d.bad_sw >= thr) nxt_d.st = ST_HUNT;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_HUNT, bad_a: '0, bad_sw: '0, rra: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign lfa_d = (nxt_d.st != ST_SYNC);
    assign lfa_q = (cur_q.st != ST_SYNC);
    assign rra_d = nxt_d.rra;
endmodule

// File: rtl/e1fas_mf_align.sv
module e1fas_mf_align #(
    parameter int MF_FRAMES = 16,
    parameter int MF_GOOD   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_en,
    input  logic lfa_q,
    input  logic vld_align,
    input  logic vld_sw,
    input  logic align_ok,
    output logic lmfa
);
    localparam int IDX_W  = $clog2(MF_FRAMES);
    localparam int GOOD_W = $clog2(MF_GOOD + 1);

    typedef struct packed {
        logic              lost;
        logic [IDX_W-1:0]  idx;
        logic [GOOD_W-1:0] good;
        logic              err;
    } mf_t;

    mf_t  cur_q, nxt_d;
    logic err_now;

    always_comb begin
        nxt_d   = cur_q;
        err_now = cur_q.err | (vld_align & ~align_ok);
        if (!cfg_en || lfa_q) begin
            nxt_d = '{lost: 1'b1, idx: '0, good: '0, err: 1'b0};
        end else if (cur_q.lost && (vld_align || vld_sw)) begin
            if (cur_q.idx == IDX_W'(MF_FRAMES - 1)) begin
                nxt_d.idx = '0;
                nxt_d.err = 1'b0;
                if (err_now) begin
                    nxt_d.good = '0;
                end else if ((cur_q.good + GOOD_W'(1)) == GOOD_W'(MF_GOOD)) begin
                    nxt_d.lost = 1'b0;
                    nxt_d.good = '0;
                end else begin
                    nxt_d.good = cur_q.good + GOOD_W'(1);
                end
            end else begin
                nxt_d.idx = cur_q.idx + IDX_W'(1);
                nxt_d.err = err_now;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{lost: 1'b1, idx: '0, good: '0, err: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign lmfa = cfg_en & cur_q.lost;
endmodule

// File: rtl/e1fas_status_irq.sv
module e1fas_status_irq
    import e1fas_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lfa_real_d,
    input  logic             rra_real_d,
    input  logic             cfg_sim,
    input  logic             irq_clr,
    output logic             st_lfa,
    output logic             st_rra,
    output logic [IRQ_N-1:0] irq
);
    typedef struct packed {
        logic             lfa;
        logic             rra;
        logic [IRQ_N-1:0] irq;
    } stat_t;

    stat_t            cur_q, nxt_d;
    logic [IRQ_N-1:0] ev;

    always_comb begin
        nxt_d.lfa    = lfa_real_d | cfg_sim;
        nxt_d.rra    = rra_real_d | cfg_sim;
        ev[IRQ_LFA]  =  nxt_d.lfa & ~cur_q.lfa;
        ev[IRQ_FAR]  = ~nxt_d.lfa &  cur_q.lfa;
        ev[IRQ_RA]   =  nxt_d.rra & ~cur_q.rra;
        ev[IRQ_RAR]  = ~nxt_d.rra &  cur_q.rra;
        for (int i = 0; i < IRQ_N; i++) begin
            nxt_d.irq[i] = ev[i] | (cur_q.irq[i] & ~irq_clr);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{lfa: 1'b1, rra: 1'b0, irq: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign st_lfa = cur_q.lfa;
    assign st_rra = cur_q.rra;
    assign irq    = cur_q.irq;
endmodule

// File: rtl/e1fas_supervisor.sv
module e1fas_supervisor
    import e1fas_pkg::*;
#(
    parameter int LOSS_LO   = 3,
    parameter int LOSS_HI   = 4,
    parameter int MF_FRAMES = 16,
    parameter int MF_GOOD   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             oct_vld,
    input  logic [OCT_W-1:0] oct_data,
    input  logic             oct_fas_slot,
    input  logic             cfg_loss4,
    input  logic             cfg_sw_chk_en,
    input  logic             cfg_crc_mf_en,
    input  logic             cfg_sim,
    input  logic             irq_clr,
    output logic             st_lfa,
    output logic             st_rra,
    output logic             st_lmfa,
    output logic             irq_lfa,
    output logic             irq_far,
    output logic             irq_ra,
    output logic             irq_rar
);
    logic             vld_align, vld_sw, align_ok, sw_keep, sw_ra;
    logic             lfa_d, lfa_real, rra_d;
    logic [IRQ_N-1:0] irq;

    e1fas_word_check i_word (
        .oct_vld      (oct_vld),
        .oct_data     (oct_data),
        .oct_fas_slot (oct_fas_slot),
        .vld_align    (vld_align),
        .vld_sw       (vld_sw),
        .align_ok     (align_ok),
        .sw_keep      (sw_keep),
        .sw_ra        (sw_ra)
    );

    e1fas_align_fsm #(.LOSS_LO(LOSS_LO), .LOSS_HI(LOSS_HI)) i_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .vld_align     (vld_align),
        .vld_sw        (vld_sw),
        .align_ok      (align_ok),
        .sw_keep       (sw_keep),
        .sw_ra         (sw_ra),
        .cfg_loss4     (cfg_loss4),
        .cfg_sw_chk_en (cfg_sw_chk_en),
        .lfa_d         (lfa_d),
        .lfa_q         (lfa_real),
        .rra_d         (rra_d)
    );

    e1fas_mf_align #(.MF_FRAMES(MF_FRAMES), .MF_GOOD(MF_GOOD)) i_mf (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_en    (cfg_crc_mf_en),
        .lfa_q     (lfa_real),
        .vld_align (vld_align),
        .vld_sw    (vld_sw),
        .align_ok  (align_ok),
        .lmfa      (st_lmfa)
    );

    e1fas_status_irq i_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .lfa_real_d (lfa_d),
        .rra_real_d (rra_d),
        .cfg_sim    (cfg_sim),
        .irq_clr    (irq_clr),
        .st_lfa     (st_lfa),
        .st_rra     (st_rra),
        .irq        (irq)
    );

    assign irq_lfa = irq[IRQ_LFA];
    assign irq_far = irq[IRQ_FAR];
    assign irq_ra  = irq[IRQ_RA];
    assign irq_rar = irq[IRQ_RAR];
endmodule

// File: rtl/e1fas_supervisor_chk.sv
module e1fas_supervisor_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_sim,
    input logic cfg_crc_mf_en,
    input logic irq_clr,
    input logic st_lfa,
    input logic st_rra,
    input logic st_lmfa,
    input logic irq_lfa,
    input logic irq_far,
    input logic irq_ra,
    input logic lfa_real
);
    // R6
    lfa_rise_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_lfa) |-> irq_lfa);
    // R6
    far_fall_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_lfa) |-> irq_far);
    // R7
    ra_rise_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_rra) |-> irq_ra);
    // R8
    sim_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_sim |=> (st_lfa && st_rra));
    // R9
    lmfa_on_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lfa_real && cfg_crc_mf_en) |=> (st_lmfa || !cfg_crc_mf_en));
    // R10
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lfa && !irq_clr) |=> irq_lfa);
endmodule

bind e1fas_supervisor e1fas_supervisor_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_sim       (cfg_sim),
    .cfg_crc_mf_en (cfg_crc_mf_en),
    .irq_clr       (irq_clr),
    .st_lfa        (st_lfa),
    .st_rra        (st_rra),
    .st_lmfa       (st_lmfa),
    .irq_lfa       (irq_lfa),
    .irq_far       (irq_far),
    .irq_ra        (irq_ra),
    .lfa_real      (lfa_real)
);

// File: tb/test_e1fas_supervisor.sv
`timescale 1ns/1ps
module test_e1fas_supervisor;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       oct_vld = 1'b0;
    logic [7:0] oct_data = 8'h00;
    logic       oct_fas_slot = 1'b0;
    logic       cfg_loss4 = 1'b0;
    logic       cfg_sw_chk_en = 1'b1;
    logic       cfg_crc_mf_en = 1'b0;
    logic       cfg_sim = 1'b0;
    logic       irq_clr = 1'b0;
    logic       st_lfa, st_rra, st_lmfa, irq_lfa, irq_far, irq_ra, irq_rar;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    e1fas_supervisor i_e1fas_supervisor (
        .clk(clk), .rst_n(rst_n), .oct_vld(oct_vld), .oct_data(oct_data),
        .oct_fas_slot(oct_fas_slot), .cfg_loss4(cfg_loss4),
        .cfg_sw_chk_en(cfg_sw_chk_en), .cfg_crc_mf_en(cfg_crc_mf_en),
        .cfg_sim(cfg_sim), .irq_clr(irq_clr), .st_lfa(st_lfa), .st_rra(st_rra),
        .st_lmfa(st_lmfa), .irq_lfa(irq_lfa), .irq_far(irq_far),
        .irq_ra(irq_ra), .irq_rar(irq_rar)
    );

    typedef struct packed {
        logic [7:0] oct;
        logic       slot;
        logic       lfa;
        logic       rra;
    } vec_t;

    // 1B/9B = good alignment word, 40 = service ok, 60 = service + alarm, 00 = bad
    localparam vec_t VEC [33] = '{
        '{8'h1B,1'b1,1'b1,1'b0}, '{8'h40,1'b0,1'b1,1'b0}, '{8'h1B,1'b1,1'b0,1'b0},
        '{8'h60,1'b0,1'b0,1'b1}, '{8'h00,1'b1,1'b0,1'b1}, '{8'h40,1'b0,1'b0,1'b0},
        '{8'h00,1'b1,1'b0,1'b0}, '{8'h40,1'b0,1'b0,1'b0}, '{8'h00,1'b1,1'b1,1'b0},
        '{8'h40,1'b0,1'b1,1'b0}, '{8'h1B,1'b1,1'b1,1'b0}, '{8'h00,1'b0,1'b1,1'b0},
        '{8'h1B,1'b1,1'b1,1'b0}, '{8'h40,1'b0,1'b1,1'b0}, '{8'h00,1'b1,1'b1,1'b0},
        '{8'h40,1'b0,1'b1,1'b0}, '{8'h9B,1'b1,1'b1,1'b0}, '{8'h40,1'b0,1'b1,1'b0},
        '{8'h1B,1'b1,1'b0,1'b0}, '{8'h00,1'b1,1'b0,1'b0}, '{8'h40,1'b0,1'b0,1'b0},
        '{8'h00,1'b1,1'b0,1'b0}, '{8'h40,1'b0,1'b0,1'b0}, '{8'h1B,1'b1,1'b0,1'b0},
        '{8'h40,1'b0,1'b0,1'b0}, '{8'h00,1'b1,1'b0,1'b0}, '{8'h40,1'b0,1'b0,1'b0},
        '{8'h00,1'b1,1'b0,1'b0}, '{8'h00,1'b0,1'b0,1'b0}, '{8'h1B,1'b1,1'b0,1'b0},
        '{8'h00,1'b0,1'b0,1'b0}, '{8'h1B,1'b1,1'b0,1'b0}, '{8'h00,1'b0,1'b1,1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d, input logic slot);
        oct_data     = d;
        oct_fas_slot = slot;
        oct_vld      = 1'b1;
        @(negedge clk);
        oct_vld = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic clear_irq();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic regain();
        push(8'h1B, 1'b1);
        push(8'h40, 1'b0);
        push(8'h1B, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        // R11 reset state
        chk("R11 st_lfa", st_lfa, 1);
        chk("R11 st_rra", st_rra, 0);
        chk("R11 irq_lfa", irq_lfa, 0);
        chk("R11 irq_far", irq_far, 0);
        chk("R11 st_lmfa", st_lmfa, 0);

        // table: R1 R2 R3 R4 R5 R7
        for (int i = 0; i < 33; i++) begin
            push(VEC[i].oct, VEC[i].slot);
            chk($sformatf("table step %0d R2 R3 R4 R5 lfa", i), st_lfa, VEC[i].lfa);
            chk($sformatf("table step %0d R1 R7 rra", i), st_rra, VEC[i].rra);
        end
        chk("R6 irq_lfa after losses", irq_lfa, 1);
        chk("R6 irq_far after regains", irq_far, 1);
        chk("R7 irq_ra", irq_ra, 1);
        chk("R7 irq_rar", irq_rar, 1);

        // R10 clear
        clear_irq();
        chk("R10 cleared lfa", irq_lfa, 0);
        chk("R10 cleared far", irq_far, 0);
        chk("R10 cleared ra", irq_ra, 0);
        chk("R10 cleared rar", irq_rar, 0);

        // R10 event wins over clear in the same cycle
        push(8'h1B, 1'b1);
        push(8'h40, 1'b0);
        irq_clr = 1'b1;
        push(8'h1B, 1'b1);
        irq_clr = 1'b0;
        chk("R4 regain with clear", st_lfa, 0);
        chk("R10 far kept over clear", irq_far, 1);
        chk("R10 lfa stays clear", irq_lfa, 0);
        clear_irq();

        // R2 threshold four
        cfg_loss4 = 1'b1;
        push(8'h00, 1'b1); push(8'h40, 1'b0);
        push(8'h00, 1'b1); push(8'h40, 1'b0);
        push(8'h00, 1'b1);
        chk("R2 three bad with threshold 4", st_lfa, 0);
        push(8'h40, 1'b0);
        push(8'h00, 1'b1);
        chk("R2 four bad with threshold 4", st_lfa, 1);
        chk("R6 irq_lfa on rise", irq_lfa, 1);

        // R3 service criterion disabled
        cfg_sw_chk_en = 1'b0;
        regain();
        chk("R4 regained", st_lfa, 0);
        for (int k = 0; k < 4; k++) begin
            push(8'h00, 1'b0);
            push(8'h1B, 1'b1);
        end
        chk("R3 bad service ignored when disabled", st_lfa, 0);
        push(8'h40, 1'b0);

        // R8 simulation
        clear_irq();
        cfg_sim = 1'b1;
        idle();
        chk("R8 sim lfa", st_lfa, 1);
        chk("R8 sim rra", st_rra, 1);
        chk("R8 sim irq_lfa", irq_lfa, 1);
        chk("R8 sim irq_ra", irq_ra, 1);
        cfg_sim = 1'b0;
        idle();
        chk("R8 release lfa", st_lfa, 0);
        chk("R8 release rra", st_rra, 0);
        chk("R8 release irq_far", irq_far, 1);
        chk("R8 release irq_rar", irq_rar, 1);

        // R8 release blocked by a real loss
        cfg_sw_chk_en = 1'b1;
        cfg_loss4     = 1'b0;
        push(8'h00, 1'b1); push(8'h40, 1'b0);
        push(8'h00, 1'b1); push(8'h40, 1'b0);
        push(8'h00, 1'b1);
        chk("R2 real loss", st_lfa, 1);
        clear_irq();
        cfg_sim = 1'b1;
        idle();
        cfg_sim = 1'b0;
        idle();
        chk("R8 real loss holds lfa", st_lfa, 1);
        chk("R8 no recovery flag", irq_far, 0);

        // R9 multiframe regain
        cfg_crc_mf_en = 1'b1;
        idle();
        chk("R9 lmfa while lost", st_lmfa, 1);
        regain();
        for (int k = 0; k < 32; k++) begin
            push((k % 2) ? 8'h1B : 8'h40, logic'(k % 2));
            if (k == 30) chk("R9 lmfa before second multiframe end", st_lmfa, 1);
        end
        chk("R9 lmfa cleared after two multiframes", st_lmfa, 0);

        // R9 loss, then error multiframe
        push(8'h40, 1'b0); push(8'h00, 1'b1);
        push(8'h40, 1'b0); push(8'h00, 1'b1);
        push(8'h40, 1'b0); push(8'h00, 1'b1);
        chk("R2 loss before multiframe test", st_lfa, 1);
        idle();
        chk("R9 lmfa follows loss", st_lmfa, 1);
        regain();
        for (int k = 0; k < 64; k++) begin
            push((k == 21) ? 8'h00 : ((k % 2) ? 8'h1B : 8'h40), logic'(k % 2));
            if (k == 47) chk("R9 errored multiframe resets count", st_lmfa, 1);
            if (k == 62) chk("R9 one good after error", st_lmfa, 1);
        end
        chk("R9 realigned after error", st_lmfa, 0);
        chk("R9 frame still aligned", st_lfa, 0);
        cfg_crc_mf_en = 1'b0;
        #1;
        chk("R9 disabled reads zero", st_lmfa, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule